// File: doc/BRIEF.md
# UART status flag controller

This block keeps the status flags of an asynchronous serial port and decides, cycle by cycle, when each flag sets and when it clears. It sits between the transmit and receive shift engines and a simple CPU register bus. The engines report events as single-cycle strobes: a transmit byte moved into the shifter, a frame finished, a received word completed (with its noise and framing qualifiers), an idle line seen, and an exit from wake-up mode.

On the bus side the block sees read strobes for the status register and read or write strobes for the data register. A flag is cleared only by a two-step sequence: a status read, then a data-register access. A data read clears the receive-side flags and a data write clears the transmit-side flags. The block returns the status byte, the receive holding register and one registered interrupt request built from the enabled sources.

Top module: `uart_flag_ctrl`

## Requirements
- R1: After reset the status byte is 0xC0, the receive holding register is 0 and the interrupt output is 0. Status bit positions are 7 transmit empty, 6 transmit complete, 5 receive ready, 4 idle, 3 overrun, 2 noise, 1 framing error, and bit 0 reads 0.
- R2: Transmit empty sets on the cycle after `tx_load_i`, and transmit complete sets on the cycle after `tx_done_i`. Both clear on the cycle after a data write that follows a status read.
- R3: A completed word that arrives while receive ready is 0 loads the holding register and sets receive ready. The word's noise qualifier sets the noise flag, and its framing qualifier sets the framing flag.
- R4: A completed word that arrives while receive ready is 1 sets the overrun flag and leaves the holding register unchanged.
- R5: A word that causes an overrun never sets the framing flag, even when its framing qualifier is 1.
- R6: The receive ready, idle, overrun, noise and framing flags clear on the cycle after a data read that follows a status read. A data access that follows no status read clears nothing and leaves the sequence disarmed.
- R7: While `rx_en_i` is 0, all five receive-side flags read 0 and receive events have no effect on them or on the holding register.
- R8: The idle flag sets on an idle strobe only while idle detection is armed. Detection is armed at reset and again each time a word loads the holding register, and it is disarmed when the idle flag sets. An idle strobe that arrives together with `wake_exit_i` sets nothing and does not disarm detection.
- R9: When a set event and a completing clear sequence meet in the same cycle, the flag ends up set.
- R10: `irq_o` is a register holding the OR of transmit empty and `tie_i`, transmit complete and `tcie_i`, receive ready or overrun with `rie_i`, and idle with `ilie_i`. The noise and framing flags do not feed it. It follows the flags one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_load_i | input | 1 | Transmit byte moved into the shifter |
| tx_done_i | input | 1 | Data, preamble or break frame finished |
| rx_word_i | input | 1 | Receive word complete |
| rx_data_i | input | DW | Completed receive word |
| rx_noise_i | input | 1 | Noise seen on the completed word |
| rx_ferr_i | input | 1 | Framing error on the completed word |
| idle_det_i | input | 1 | Idle line detected |
| wake_exit_i | input | 1 | Receiver leaving wake-up mode |
| rx_en_i | input | 1 | Receiver enable |
| tie_i | input | 1 | Transmit-empty interrupt enable |
| tcie_i | input | 1 | Transmit-complete interrupt enable |
| rie_i | input | 1 | Receive interrupt enable |
| ilie_i | input | 1 | Idle interrupt enable |
| stat_rd_i | input | 1 | Status register read strobe |
| data_rd_i | input | 1 | Data register read strobe |
| data_wr_i | input | 1 | Data register write strobe |
| status_o | output | 8 | Status byte |
| rx_buf_o | output | DW | Receive holding register |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions treat every event and bus input as a one-cycle strobe sampled on the rising edge. They take the noise and framing qualifiers as meaningful only in a cycle where `rx_word_i` is high. The random stimulus drives all inputs on the falling edge and keeps the bus strobes mutually exclusive. It holds the receiver enabled most of the time and disables it only in occasional stretches. Event strobes are drawn with a low probability, so that clear sequences, overruns and set-versus-clear collisions all come up.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  localparam int unsigned ST_TXE  = 7;
  localparam int unsigned ST_TC   = 6;
  localparam int unsigned ST_RXNE = 5;
  localparam int unsigned ST_IDLE = 4;
  localparam int unsigned ST_OVR  = 3;
  localparam int unsigned ST_NF   = 2;
  localparam int unsigned ST_FE   = 1;

  typedef struct packed {
    logic rxne;
    logic idle;
    logic ovr;
    logic nf;
    logic fe;
  } rx_flags_t;
endpackage

// File: rtl/uart_seq_track.sv
module uart_seq_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stat_rd_i,
  input  logic data_rd_i,
  input  logic data_wr_i,
  output logic rx_clr_o,
  output logic tx_clr_o
);
  logic armed_q;

  assign rx_clr_o = armed_q & data_rd_i;
  assign tx_clr_o = armed_q & data_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    armed_q <= 1'b0;
    else if (stat_rd_i)             armed_q <= 1'b1;
    else if (data_rd_i | data_wr_i) armed_q <= 1'b0;
  end
endmodule

// File: rtl/uart_tx_flags.sv
module uart_tx_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic done_i,
  input  logic clr_i,
  output logic txe_o,
  output logic tc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txe_o <= 1'b1;
      tc_o  <= 1'b1;
    end else begin
      // set dominates clear
      if (load_i)     txe_o <= 1'b1;
      else if (clr_i) txe_o <= 1'b0;
      if (done_i)     tc_o  <= 1'b1;
      else if (clr_i) tc_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import uart_flag_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_en_i,
  input  logic          word_i,
  input  logic [DW-1:0] data_i,
  input  logic          noise_i,
  input  logic          ferr_i,
  input  logic          idle_det_i,
  input  logic          wake_exit_i,
  input  logic          clr_i,
  output rx_flags_t     flags_o,
  output logic [DW-1:0] buf_o
);
  rx_flags_t fl_q;
  logic      arm_q;
  logic      load, ovr_ev, idle_set;

  assign load     = rx_en_i & word_i & ~fl_q.rxne;
  assign ovr_ev   = rx_en_i & word_i & fl_q.rxne;
  assign idle_set = rx_en_i & idle_det_i & arm_q & ~wake_exit_i;
  assign flags_o  = fl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fl_q  <= '0;
      arm_q <= 1'b1;
      buf_o <= '0;
    end else if (!rx_en_i) begin
      fl_q <= '0;
    end else begin
      if (load)                   fl_q.rxne <= 1'b1;
      else if (clr_i)             fl_q.rxne <= 1'b0;
      if (ovr_ev)                 fl_q.ovr  <= 1'b1;
      else if (clr_i)             fl_q.ovr  <= 1'b0;
      if (word_i & noise_i)       fl_q.nf   <= 1'b1;
      else if (clr_i)             fl_q.nf   <= 1'b0;
      // overrun word never reports a framing error
      if (load & ferr_i)          fl_q.fe   <= 1'b1;
      else if (clr_i)             fl_q.fe   <= 1'b0;
      if (idle_set)               fl_q.idle <= 1'b1;
      else if (clr_i)             fl_q.idle <= 1'b0;
      if (load)                   arm_q <= 1'b1;
      else if (idle_set)          arm_q <= 1'b0;
      if (load)                   buf_o <= data_i;
    end
  end
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen #(
  parameter int unsigned NSRC = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] en_i,
  output logic            irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(src_i & en_i);
  end
endmodule

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
  import uart_flag_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_load_i,
  input  logic          tx_done_i,
  input  logic          rx_word_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_noise_i,
  input  logic          rx_ferr_i,
  input  logic          idle_det_i,
  input  logic          wake_exit_i,
  input  logic          rx_en_i,
  input  logic          tie_i,
  input  logic          tcie_i,
  input  logic          rie_i,
  input  logic          ilie_i,
  input  logic          stat_rd_i,
  input  logic          data_rd_i,
  input  logic          data_wr_i,
  output logic [7:0]    status_o,
  output logic [DW-1:0] rx_buf_o,
  output logic          irq_o
);
  localparam int unsigned NSRC = 4;

  logic      rx_clr, tx_clr, txe, tc;
  rx_flags_t rxf;

  uart_seq_track u_seq (
    .clk_i, .rst_ni, .stat_rd_i, .data_rd_i, .data_wr_i,
    .rx_clr_o(rx_clr), .tx_clr_o(tx_clr)
  );

  uart_tx_flags u_tx (
    .clk_i, .rst_ni, .load_i(tx_load_i), .done_i(tx_done_i),
    .clr_i(tx_clr), .txe_o(txe), .tc_o(tc)
  );

  uart_rx_flags #(.DW(DW)) u_rx (
    .clk_i, .rst_ni, .rx_en_i, .word_i(rx_word_i), .data_i(rx_data_i),
    .noise_i(rx_noise_i), .ferr_i(rx_ferr_i), .idle_det_i, .wake_exit_i,
    .clr_i(rx_clr), .flags_o(rxf), .buf_o(rx_buf_o)
  );

  uart_irq_gen #(.NSRC(NSRC)) u_irq (
    .clk_i, .rst_ni,
    .src_i({rxf.idle, rxf.rxne | rxf.ovr, tc, txe}),
    .en_i ({ilie_i, rie_i, tcie_i, tie_i}),
    .irq_o
  );

  always_comb begin
    status_o          = '0;
    status_o[ST_TXE]  = txe;
    status_o[ST_TC]   = tc;
    status_o[ST_RXNE] = rxf.rxne;
    status_o[ST_IDLE] = rxf.idle;
    status_o[ST_OVR]  = rxf.ovr;
    status_o[ST_NF]   = rxf.nf;
    status_o[ST_FE]   = rxf.fe;
  end
endmodule

// File: rtl/uart_flag_ctrl_chk.sv
module uart_flag_ctrl_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tx_load_i,
  input logic          rx_word_i,
  input logic          rx_ferr_i,
  input logic          idle_det_i,
  input logic          wake_exit_i,
  input logic          rx_en_i,
  input logic          tie_i,
  input logic          tcie_i,
  input logic          rie_i,
  input logic          ilie_i,
  input logic [7:0]    status_o,
  input logic [DW-1:0] rx_buf_o,
  input logic          irq_o
);
  assert_txe_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_i |=> status_o[7]);

  assert_ovr_keeps_buf_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_word_i && rx_en_i && status_o[5]) |=> (status_o[3] && $stable(rx_buf_o)));

  assert_no_fe_on_ovr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_word_i && rx_ferr_i && rx_en_i && status_o[5] && !status_o[1]) |=> !status_o[1]);

  assert_rx_off_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> (status_o[5:1] == 5'b0));

  assert_wake_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_det_i && wake_exit_i && !status_o[4]) |=> !status_o[4]);

  assert_irq_reg_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past((status_o[7] & tie_i) | (status_o[6] & tcie_i) |
                            ((status_o[5] | status_o[3]) & rie_i) | (status_o[4] & ilie_i)));

  always_ff @(posedge clk_i) begin
    if (rst_ni) assert_bit0_zero_R1: assert (status_o[0] == 1'b0);
  end
endmodule

bind uart_flag_ctrl uart_flag_ctrl_chk #(.DW(DW)) u_chk (
  .clk_i, .rst_ni, .tx_load_i, .rx_word_i, .rx_ferr_i, .idle_det_i,
  .wake_exit_i, .rx_en_i, .tie_i, .tcie_i, .rie_i, .ilie_i,
  .status_o, .rx_buf_o, .irq_o
);

// File: tb/uart_flag_ctrl_tb_top.sv
`timescale 1ns/1ps
module uart_flag_ctrl_tb_top;
  localparam int DW = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic tx_load_i = 0, tx_done_i = 0, rx_word_i = 0, rx_noise_i = 0, rx_ferr_i = 0;
  logic idle_det_i = 0, wake_exit_i = 0, rx_en_i = 1;
  logic tie_i = 0, tcie_i = 0, rie_i = 0, ilie_i = 0;
  logic stat_rd_i = 0, data_rd_i = 0, data_wr_i = 0;
  logic [DW-1:0] rx_data_i = '0;
  logic [7:0]    status_o;
  logic [DW-1:0] rx_buf_o;
  logic          irq_o;

  int n_chk = 0, n_fail = 0, seed = 12345;

  // bench model
  logic m_txe, m_tc, m_rxne, m_idle, m_ovr, m_nf, m_fe, m_arm, m_seq, m_irq;
  logic [DW-1:0] m_buf;

  always #5 clk_i = ~clk_i;

  uart_flag_ctrl #(.DW(DW)) dut_i (.*);

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  function automatic logic [7:0] m_status();
    return {m_txe, m_tc, m_rxne, m_idle, m_ovr, m_nf, m_fe, 1'b0};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_txe = 1; m_tc = 1; {m_rxne, m_idle, m_ovr, m_nf, m_fe} = '0;
    m_arm = 1; m_seq = 0; m_irq = 0; m_buf = '0;
  endtask

  // advance one edge in model and design, then compare
  task automatic tick();
    logic rclr, tclr, load, ovr_ev, iset, irq_n;
    irq_n = (m_txe & tie_i) | (m_tc & tcie_i) | ((m_rxne | m_ovr) & rie_i) | (m_idle & ilie_i);
    rclr = m_seq & data_rd_i;
    tclr = m_seq & data_wr_i;
    m_seq = stat_rd_i ? 1'b1 : (data_rd_i | data_wr_i) ? 1'b0 : m_seq;
    m_txe = tx_load_i ? 1'b1 : (tclr ? 1'b0 : m_txe);
    m_tc  = tx_done_i ? 1'b1 : (tclr ? 1'b0 : m_tc);
    if (!rx_en_i) begin
      {m_rxne, m_idle, m_ovr, m_nf, m_fe} = '0;
    end else begin
      load   = rx_word_i & ~m_rxne;
      ovr_ev = rx_word_i & m_rxne;
      iset   = idle_det_i & m_arm & ~wake_exit_i;
      m_rxne = load ? 1'b1 : (rclr ? 1'b0 : m_rxne);
      m_ovr  = ovr_ev ? 1'b1 : (rclr ? 1'b0 : m_ovr);
      m_nf   = (rx_word_i & rx_noise_i) ? 1'b1 : (rclr ? 1'b0 : m_nf);
      m_fe   = (load & rx_ferr_i) ? 1'b1 : (rclr ? 1'b0 : m_fe);
      m_idle = iset ? 1'b1 : (rclr ? 1'b0 : m_idle);
      if (load) m_arm = 1'b1; else if (iset) m_arm = 1'b0;
      if (load) m_buf = rx_data_i;
    end
    m_irq = irq_n;
    @(posedge clk_i);
    @(negedge clk_i);
    chk(status_o[7:6], {m_txe, m_tc}, "R2 tx flags");
    chk(status_o[5], m_rxne, "R3 rx ready");
    chk(status_o[4], m_idle, "R8 idle");
    chk(status_o[3], m_ovr, "R4 overrun");
    chk(status_o[2:1], {m_nf, m_fe}, "R5 noise/framing");
    chk(rx_buf_o, m_buf, "R4 holding register");
    chk(irq_o, m_irq, "R10 irq");
  endtask

  task automatic idle_in();
    {tx_load_i, tx_done_i, rx_word_i, rx_noise_i, rx_ferr_i, idle_det_i, wake_exit_i} = '0;
    {stat_rd_i, data_rd_i, data_wr_i} = '0;
  endtask

  task automatic rx_word(input logic [DW-1:0] d, input logic fe, input logic nz);
    idle_in(); rx_word_i = 1; rx_data_i = d; rx_ferr_i = fe; rx_noise_i = nz; tick();
  endtask

  task automatic bus(input logic s, input logic r, input logic w);
    idle_in(); stat_rd_i = s; data_rd_i = r; data_wr_i = w; tick();
  endtask

  initial begin
    int rv;
    model_reset();
    rv = $urandom(seed);
    repeat (3) @(negedge clk_i);
    chk(status_o, 8'hC0, "R1 reset status");
    chk(rx_buf_o, '0, "R1 reset buffer");
    chk(irq_o, 1'b0, "R1 reset irq");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(status_o, 8'hC0, "R1 status after release");

    // R2: clear tx flags through status read then data write
    bus(1, 0, 0); bus(0, 0, 1);
    chk(status_o[7:6], 2'b00, "R2 tx clear");
    idle_in(); tx_load_i = 1; tick(); idle_in(); tick();
    chk(status_o[7:6], 2'b10, "R2 txe set");

    // R3/R4/R5
    rx_word(8'h5A, 0, 1);
    chk(rx_buf_o, 8'h5A, "R3 load"); chk(status_o[5], 1, "R3 rxne"); chk(status_o[2], 1, "R3 noise");
    rx_word(8'h33, 1, 0);
    chk(status_o[3], 1, "R4 overrun"); chk(rx_buf_o, 8'h5A, "R4 kept");
    chk(status_o[1], 0, "R5 framing suppressed");

    // R6: unarmed data read does nothing, armed one clears
    bus(1, 0, 0); bus(0, 0, 1); bus(0, 1, 0);
    chk(status_o[5:3], 3'b101, "R6 no clear when disarmed");
    bus(1, 0, 0); bus(0, 1, 0);
    chk(status_o[5:1], 5'b0, "R6 rx clear");

    // R8: idle rearm and wake exit
    idle_in(); idle_det_i = 1; tick();
    chk(status_o[4], 1, "R8 idle set");
    bus(1, 0, 0); bus(0, 1, 0);
    idle_in(); idle_det_i = 1; tick();
    chk(status_o[4], 0, "R8 not rearmed");
    rx_word(8'hA1, 1, 0);
    chk(status_o[1], 1, "R3 framing set");
    bus(1, 0, 0); bus(0, 1, 0);
    idle_in(); idle_det_i = 1; wake_exit_i = 1; tick();
    chk(status_o[4], 0, "R8 wake exit ignored");
    idle_in(); idle_det_i = 1; tick();
    chk(status_o[4], 1, "R8 rearmed by new word");

    // R9: set wins against clear
    bus(1, 0, 0);
    idle_in(); data_wr_i = 1; tx_done_i = 1; tick();
    chk(status_o[7:6], 2'b01, "R9 set wins");

    // R7: receiver disabled
    rx_word(8'h77, 0, 0);
    idle_in(); rx_en_i = 0; rx_word_i = 1; rx_data_i = 8'h11; idle_det_i = 1; tick();
    chk(status_o[5:1], 5'b0, "R7 disabled clears");
    chk(rx_buf_o, 8'h77, "R7 buffer untouched");
    rx_en_i = 1;

    // R10: irq timing
    idle_in(); tie_i = 1; tx_load_i = 1; tick();
    chk(irq_o, 0, "R10 irq one cycle late");
    idle_in(); tick();
    chk(irq_o, 1, "R10 irq raised");
    tie_i = 0; tick();
    chk(irq_o, 0, "R10 irq dropped");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int b;
      idle_in();
      tx_load_i  = ($urandom % 8) == 0;
      tx_done_i  = ($urandom % 8) == 0;
      rx_word_i  = ($urandom % 5) == 0;
      rx_data_i  = DW'($urandom);
      rx_noise_i = ($urandom % 4) == 0;
      rx_ferr_i  = ($urandom % 4) == 0;
      idle_det_i = ($urandom % 6) == 0;
      wake_exit_i = ($urandom % 4) == 0;
      if ((i % 200) == 150) rx_en_i = 0;
      if ((i % 200) == 160) rx_en_i = 1;
      {tie_i, tcie_i, rie_i, ilie_i} = 4'($urandom);
      b = $urandom % 6;
      stat_rd_i = (b == 0) || (b == 1);
      data_rd_i = (b == 2);
      data_wr_i = (b == 3);
      tick();
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule